// File: doc/BRIEF.md
# Key-Protected Clock and Power Controller

This block sits on the special-function-register bus of a small metering microcontroller. It runs on the 4.096 MHz PLL clock and holds one power/clock control register. Software can change that register only through a two-step sequence. First it writes an unlock key to a separate key register. Then it writes the new value. A second key value opens a single write to a group of five timekeeping registers. Those registers live elsewhere, and this block only raises a one-shot write-enable for them.

From the PLL clock the block produces two single-cycle clock enables. The core enable fires once every 2^CD cycles, where CD is the 3-bit divide field of the control register. The measurement enable fires once every five cycles for every CD setting. The block also watches the PLL lock indication. A loss of lock pulses a core reset and sets a sticky fault flag. Software reads that flag and clears it by writing an acknowledge bit. The meter-off and core-off bits of the control register are driven straight out to the power-management logic.

Top module: `clkpwr_keyed_ctrl`

## Requirements
- R1: A write to the control register (address 0x11) is applied only if the SFR write just before it was a write of 0xA7 to the key register (address 0x10). Otherwise it is ignored.
- R2: After 0xEA is written to the key register, the next SFR write drives `time_wr_en` high during that write's cycle, provided it targets one of the timekeeping addresses 0x18 to 0x1C. `time_wr_en` is never high at any other time.
- R3: A loaded key is used up by the very next SFR write to any address. A write to another register, or a key write of another value, cancels the unlock.
- R4: After reset the control register reads 0x82, which is CD = 010. Read layout: bit 7 always reads 1, bit 6 is meter-off, bit 5 and bit 3 always read 0, bit 4 is core-off, bits 2:0 are CD.
- R5: `core_clk_en` is high for one cycle in every 2^CD PLL cycles. After reset is released, the first pulse comes on the fourth clock.
- R6: A new CD value takes effect only after the current divide period ends, so no interval between core pulses is shorter than the old or the new period.
- R7: `meas_clk_en` is high for one cycle in every 5 PLL cycles, whatever the value of CD.
- R8: When `pll_locked` falls, `core_rst` is high for the next 16 cycles. The fault flag is set, and it reads as bit 0 of the status address 0x12 and on `pll_fault`.
- R9: The fault flag stays set through the core reset and through any other writes. Only a write with bit 0 set to the acknowledge address 0x13 clears it. A new loss of lock in the same cycle as the acknowledge wins.
- R10: `meter_off` follows bit 6 of the control register and `core_off` follows bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4.096 MHz PLL clock |
| rst_n | input | 1 | Power-on reset, active low |
| sfr_addr | input | 8 | SFR address |
| sfr_wdata | input | 8 | SFR write data |
| sfr_we | input | 1 | SFR write strobe, one cycle per write |
| sfr_rdata | output | 8 | Read data for `sfr_addr`, combinational |
| pll_locked | input | 1 | PLL lock indication |
| core_clk_en | output | 1 | Core clock enable, PLL/2^CD |
| meas_clk_en | output | 1 | Measurement clock enable, PLL/5 |
| core_rst | output | 1 | Core reset pulse after loss of lock |
| pll_fault | output | 1 | Sticky loss-of-lock flag |
| meter_off | output | 1 | Power down modulators and metering DSP |
| core_off | output | 1 | Core shut-down request |
| time_wr_en | output | 1 | One-shot timekeeping write enable |

## Verification
The unlock logic is driven with four kinds of pattern:
- a bare control write;
- a correct key followed by the write;
- a correct key followed by an unrelated write and then the control write;
- a correct key overwritten by a wrong key.

Together these separate "key required" from "key consumed". The timekeeping key is followed by an in-group write, a repeated write, and a control-register write. This shows that the two keys open different groups and that each key opens only one write. The divider is swept through CD values 0, 7, 1 and 3, with changes made in the middle of a period, to catch early switching. Loss of lock is tested with an acknowledge of bit 0 clear, an acknowledge of bit 0 set, and an acknowledge in the same cycle as a new loss of lock. The reference model is compared on every cycle.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
   typedef enum logic [1:0] {
      KEY_NONE = 2'd0,
      KEY_PWR  = 2'd1,
      KEY_TIME = 2'd2
   } key_state_e;

   localparam int PWR_BIT_FIXED1  = 7;
   localparam int PWR_BIT_METER   = 6;
   localparam int PWR_BIT_COREOFF = 4;
   localparam int PWR_CD_W        = 3;
   localparam logic [PWR_CD_W-1:0] PWR_CD_RESET = 3'b010;
endpackage

// File: rtl/clkpwr_keylock.sv
module clkpwr_keylock
   import clkpwr_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter int ADDR_KEY     = 'h10,
   parameter int ADDR_PWR     = 'h11,
   parameter int TIME_BASE    = 'h18,
   parameter int TIME_CNT     = 5,
   parameter int KEY_PWR_VAL  = 'hA7,
   parameter int KEY_TIME_VAL = 'hEA
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          pwr_wr_ok,
   output logic          time_wr_en
);
   key_state_e key_q;
   logic       hit_key, hit_pwr, hit_time;

   if (TIME_CNT < 1) begin : g_bad_cnt
      $error("clkpwr_keylock: TIME_CNT must be at least 1");
   end
   if (KEY_PWR_VAL == KEY_TIME_VAL) begin : g_bad_keys
      $error("clkpwr_keylock: the two key values must differ");
   end

   assign hit_key  = (int'(addr) == ADDR_KEY);
   assign hit_pwr  = (int'(addr) == ADDR_PWR);
   assign hit_time = (int'(addr) >= TIME_BASE) && (int'(addr) < TIME_BASE + TIME_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= KEY_NONE;
      end else if (we) begin
         if (hit_key && int'(wdata) == KEY_PWR_VAL)       key_q <= KEY_PWR;
         else if (hit_key && int'(wdata) == KEY_TIME_VAL) key_q <= KEY_TIME;
         else                                             key_q <= KEY_NONE;
      end
   end

   assign pwr_wr_ok  = we && hit_pwr  && (key_q == KEY_PWR);
   assign time_wr_en = we && hit_time && (key_q == KEY_TIME);

   a_r2_time_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr_en |-> we);
   a_r3_time_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      time_wr_en |=> !time_wr_en);
   a_r3_pwr_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_wr_ok |=> !pwr_wr_ok);
endmodule

// File: rtl/clkpwr_pow2_div.sv
module clkpwr_pow2_div #(
   parameter int CD_W = 3,
   parameter logic [CD_W-1:0] CD_RESET = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CD_W-1:0] cd_req,
   output logic            en
);
   localparam int CNT_W = (1 << CD_W) - 1;
   localparam int LIM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CD_W-1:0]  cd_act_q;
   logic [LIM_W-1:0] lim_w;

   if (CD_W < 1 || CD_W > 4) begin : g_bad_cdw
      $error("clkpwr_pow2_div: CD_W must be 1..4");
   end

   assign lim_w = (LIM_W'(1) << cd_act_q) - LIM_W'(1);
   assign en    = (cnt_q == lim_w[CNT_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         cd_act_q <= CD_RESET;
      end else if (en) begin
         cnt_q    <= '0;
         cd_act_q <= cd_req;
      end else begin
         cnt_q    <= cnt_q + CNT_W'(1);
      end
   end

   a_r6_cd_holds_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(cd_act_q));
   a_r5_restart_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cnt_q == '0));
endmodule

// File: rtl/clkpwr_fixed_div.sv
module clkpwr_fixed_div #(
   parameter int DIV = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic en
);
   if (DIV < 1) begin : g_bad_div
      $error("clkpwr_fixed_div: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign en = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;

      assign en = (int'(cnt_q) == DIV - 1);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  cnt_q <= '0;
         else if (en) cnt_q <= '0;
         else         cnt_q <= cnt_q + CW'(1);
      end

      a_r7_meas_gap: assert property (@(posedge clk) disable iff (!rst_n)
         en |=> !en);
   end
endmodule

// File: rtl/clkpwr_fault.sv
module clkpwr_fault #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pll_locked,
   input  logic ack,
   output logic fault,
   output logic core_rst
);
   localparam int CW = $clog2(HOLD + 1);

   logic          lock_prev_q;
   logic          drop;
   logic [CW-1:0] hold_q;

   if (HOLD < 1) begin : g_bad_hold
      $error("clkpwr_fault: HOLD must be at least 1");
   end

   assign drop     = lock_prev_q && !pll_locked;
   assign core_rst = (hold_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_prev_q <= 1'b1;
         fault       <= 1'b0;
         hold_q      <= '0;
      end else begin
         lock_prev_q <= pll_locked;
         if (drop)          fault <= 1'b1;
         else if (ack)      fault <= 1'b0;
         if (drop)          hold_q <= CW'(HOLD);
         else if (core_rst) hold_q <= hold_q - CW'(1);
      end
   end

   a_r8_fault_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pll_locked) && !pll_locked) |=> (fault && core_rst));
   a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !ack) |=> fault);
endmodule

// File: rtl/clkpwr_keyed_ctrl.sv
module clkpwr_keyed_ctrl
   import clkpwr_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DW           = 8,
   parameter int ADDR_KEY     = 'h10,
   parameter int ADDR_PWR     = 'h11,
   parameter int ADDR_STAT    = 'h12,
   parameter int ADDR_ACK     = 'h13,
   parameter int TIME_BASE    = 'h18,
   parameter int TIME_CNT     = 5,
   parameter int KEY_PWR_VAL  = 'hA7,
   parameter int KEY_TIME_VAL = 'hEA,
   parameter int MEAS_DIV     = 5,
   parameter int RST_HOLD     = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] sfr_addr,
   input  logic [DW-1:0] sfr_wdata,
   input  logic          sfr_we,
   output logic [DW-1:0] sfr_rdata,
   input  logic          pll_locked,
   output logic          core_clk_en,
   output logic          meas_clk_en,
   output logic          core_rst,
   output logic          pll_fault,
   output logic          meter_off,
   output logic          core_off,
   output logic          time_wr_en
);
   logic                pwr_wr_ok;
   logic                ack_wr;
   logic                meter_q, coreoff_q;
   logic [PWR_CD_W-1:0] cd_q;
   logic [DW-1:0]       pwr_view;

   if (DW < 8) begin : g_bad_dw
      $error("clkpwr_keyed_ctrl: DW must be at least 8");
   end

   clkpwr_keylock #(
      .AW(AW), .DW(DW), .ADDR_KEY(ADDR_KEY), .ADDR_PWR(ADDR_PWR),
      .TIME_BASE(TIME_BASE), .TIME_CNT(TIME_CNT),
      .KEY_PWR_VAL(KEY_PWR_VAL), .KEY_TIME_VAL(KEY_TIME_VAL)
   ) u_keylock (
      .clk(clk), .rst_n(rst_n), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
      .pwr_wr_ok(pwr_wr_ok), .time_wr_en(time_wr_en)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meter_q   <= 1'b0;
         coreoff_q <= 1'b0;
         cd_q      <= PWR_CD_RESET;
      end else if (pwr_wr_ok) begin
         meter_q   <= sfr_wdata[PWR_BIT_METER];
         coreoff_q <= sfr_wdata[PWR_BIT_COREOFF];
         cd_q      <= sfr_wdata[PWR_CD_W-1:0];
      end
   end

   always_comb begin
      pwr_view                  = '0;
      pwr_view[PWR_BIT_FIXED1]  = 1'b1;
      pwr_view[PWR_BIT_METER]   = meter_q;
      pwr_view[PWR_BIT_COREOFF] = coreoff_q;
      pwr_view[PWR_CD_W-1:0]    = cd_q;
   end

   always_comb begin
      sfr_rdata = '0;
      if (int'(sfr_addr) == ADDR_PWR)       sfr_rdata = pwr_view;
      else if (int'(sfr_addr) == ADDR_STAT) sfr_rdata[0] = pll_fault;
   end

   assign meter_off = meter_q;
   assign core_off  = coreoff_q;
   assign ack_wr    = sfr_we && (int'(sfr_addr) == ADDR_ACK) && sfr_wdata[0];

   clkpwr_pow2_div #(.CD_W(PWR_CD_W), .CD_RESET(PWR_CD_RESET)) u_core_div (
      .clk(clk), .rst_n(rst_n), .cd_req(cd_q), .en(core_clk_en)
   );

   clkpwr_fixed_div #(.DIV(MEAS_DIV)) u_meas_div (
      .clk(clk), .rst_n(rst_n), .en(meas_clk_en)
   );

   clkpwr_fault #(.HOLD(RST_HOLD)) u_fault (
      .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .ack(ack_wr),
      .fault(pll_fault), .core_rst(core_rst)
   );

   a_r1_pwr_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cd_q != $past(cd_q) || meter_q != $past(meter_q))
         |-> $past(sfr_we && int'(sfr_addr) == ADDR_PWR));
   a_r10_meter_follows_reg: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(pwr_wr_ok) |-> $stable(meter_off));
endmodule

// File: tb/clkpwr_keyed_ctrl_bench.sv
module clkpwr_keyed_ctrl_bench;
   localparam int PERIOD = 10;
   localparam int A_KEY = 'h10, A_PWR = 'h11, A_STAT = 'h12, A_ACK = 'h13, A_TB = 'h18;

   logic       clk = 0, rst_n = 0, sfr_we = 0, pll_locked = 1;
   logic [7:0] sfr_addr = 0, sfr_wdata = 0, sfr_rdata;
   logic       core_clk_en, meas_clk_en, core_rst, pll_fault, meter_off, core_off, time_wr_en;

   int n_checks = 0, n_errors = 0;
   bit started = 0, done = 0;

   int m_cc = 0, m_cda = 2, m_mc = 0, m_rc = 0, m_key = 0;
   int m_cd = 2, m_meter = 0, m_coreoff = 0, m_fault = 0, m_prevlock = 1;

   always #(PERIOD/2) clk = ~clk;

   clkpwr_keyed_ctrl u_clkpwr_keyed_ctrl (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
      .sfr_we(sfr_we), .sfr_rdata(sfr_rdata), .pll_locked(pll_locked),
      .core_clk_en(core_clk_en), .meas_clk_en(meas_clk_en), .core_rst(core_rst),
      .pll_fault(pll_fault), .meter_off(meter_off), .core_off(core_off),
      .time_wr_en(time_wr_en)
   );

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // reference model, state advanced at each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cc = 0; m_cda = 2; m_mc = 0; m_rc = 0; m_key = 0;
         m_cd = 2; m_meter = 0; m_coreoff = 0; m_fault = 0; m_prevlock = 1;
      end else begin
         if (m_cc == (1 << m_cda) - 1) begin m_cc = 0; m_cda = m_cd; end
         else m_cc++;
         m_mc = (m_mc == 4) ? 0 : m_mc + 1;
         if (m_rc > 0) m_rc--;
         if (m_prevlock && !pll_locked) begin m_fault = 1; m_rc = 16; end
         else if (sfr_we && sfr_addr == A_ACK && sfr_wdata[0]) m_fault = 0;
         m_prevlock = pll_locked;
         if (sfr_we) begin
            if (sfr_addr == A_PWR && m_key == 1) begin
               m_meter = sfr_wdata[6]; m_coreoff = sfr_wdata[4]; m_cd = sfr_wdata[2:0];
            end
            if (sfr_addr == A_KEY)
               m_key = (sfr_wdata == 8'hA7) ? 1 : (sfr_wdata == 8'hEA) ? 2 : 0;
            else m_key = 0;
         end
      end
   end

   // compare every cycle, away from the rising edge
   always @(negedge clk) begin
      #1;
      if (started && !done) begin
         int exp_rd;
         exp_rd = 0;
         if (sfr_addr == A_PWR) exp_rd = 128 + m_meter*64 + m_coreoff*16 + m_cd;
         else if (sfr_addr == A_STAT) exp_rd = m_fault;
         check("R5/R6 core_clk_en", core_clk_en, (m_cc == (1 << m_cda) - 1) ? 1 : 0);
         check("R7 meas_clk_en", meas_clk_en, (m_mc == 4) ? 1 : 0);
         check("R8 core_rst", core_rst, (m_rc > 0) ? 1 : 0);
         check("R9 pll_fault", pll_fault, m_fault);
         check("R10 meter_off", meter_off, m_meter);
         check("R10 core_off", core_off, m_coreoff);
         check("R2/R3 time_wr_en", time_wr_en,
               (sfr_we && sfr_addr >= A_TB && sfr_addr < A_TB + 5 && m_key == 2) ? 1 : 0);
         check("R1/R4 sfr_rdata", sfr_rdata, exp_rd);
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      sfr_we = 1; sfr_addr = 8'(a); sfr_wdata = 8'(d);
      @(negedge clk);
      sfr_we = 0; sfr_addr = 8'(A_PWR);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(PERIOD * 150000);
      n_checks++; n_errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      sfr_addr = 8'(A_PWR);
      started = 1;                     // R4 reset values checked while held in reset
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R5: first pulse on fourth clock after release, reset readback 0x82 (R4)
      @(negedge clk); #2; check("R4 reset readback", sfr_rdata, 'h82);
      idle(20);
      // R1: bare write ignored
      wr(A_PWR, 'h40);
      @(negedge clk); #2; check("R1 unkeyed write ignored", meter_off, 0);
      // R1: keyed write, CD=0, meter off
      wr(A_KEY, 'hA7); wr(A_PWR, 'h48);
      @(negedge clk); #2; check("R4 reserved bits", sfr_rdata, 'hC0);
      idle(12);
      // R3: key then unrelated write, then control write -> ignored
      wr(A_KEY, 'hA7); wr(A_STAT, 'h00); wr(A_PWR, 'h17);
      @(negedge clk); #2; check("R3 key consumed", sfr_rdata, 'hC0);
      // R3: key overwritten by a wrong key
      wr(A_KEY, 'hA7); wr(A_KEY, 'h55); wr(A_PWR, 'h17);
      @(negedge clk); #2; check("R3 wrong key cancels", sfr_rdata, 'hC0);
      // R6/R10: CD=7, core off
      wr(A_KEY, 'hA7); wr(A_PWR, 'h17);
      @(negedge clk); #2; check("R10 core_off set", core_off, 1);
      idle(300);
      // R2: timekeeping unlock is one shot
      wr(A_KEY, 'hEA); wr(A_TB + 2, 'h11); wr(A_TB + 2, 'h12);
      wr(A_KEY, 'hEA); wr(A_TB + 4, 'h01);
      // R2/R1: time key does not open the control register
      wr(A_KEY, 'hEA); wr(A_PWR, 'h01);
      @(negedge clk); #2; check("R1 time key rejected", sfr_rdata, 'h97);
      // CD change mid-period (R6)
      wr(A_KEY, 'hA7); wr(A_PWR, 'h01);
      idle(150);
      idle(1);
      wr(A_KEY, 'hA7); wr(A_PWR, 'h03);
      idle(40);
      // R8/R9: loss of lock
      @(negedge clk); pll_locked = 0;
      idle(3); pll_locked = 1;
      idle(25);
      sfr_addr = 8'(A_STAT);
      @(negedge clk); #2; check("R9 fault survives core reset", sfr_rdata, 1);
      wr(A_ACK, 'h00);
      @(negedge clk); #2; check("R9 ack bit0 clear ignored", pll_fault, 1);
      wr(A_ACK, 'h01);
      @(negedge clk); #2; check("R9 ack clears", pll_fault, 0);
      // R9: drop in the same cycle as an ack -> set wins
      @(negedge clk);
      pll_locked = 0; sfr_we = 1; sfr_addr = 8'(A_ACK); sfr_wdata = 8'h01;
      @(negedge clk); sfr_we = 0; sfr_addr = 8'(A_STAT);
      #2; check("R9 drop beats ack", pll_fault, 1);
      idle(20);
      pll_locked = 1;
      idle(10);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule